// File: doc/BRIEF.md
# Slow-Control Register Endpoint

This block sits behind a slow-control command decoder. Each command carries a read or write operation, a 16-bit address and, for writes, a 32-bit data word. Each address selects one 32-bit word. The endpoint serves a fixed local map. That map holds a live status word, a word of one-cycle command pulses, two read/write control words and three read-only information words whose values come from parameters. It also holds a bank of user status registers and a bank of user control registers, each sized by a log2 parameter.

Every accepted command gets exactly one reply on the following cycle. The reply carries a two-bit code and, for successful local reads, the read data. Each user register has its own access strobe. A user status strobe fires on a read and a user control strobe fires on a write. Addresses from 0x100 upward belong to an external data port. When that port is enabled the command is handed to it and the reply says it was forwarded. When the port is disabled the endpoint rejects the access itself.

Top module: `sc_reg_endpoint`

## Requirements
- R1: `rsp_valid` is high in the cycle after each cycle with `cmd_valid` high, and low in every other cycle.
- R2: The reply code is 2'b00 for ok, 2'b01 for unknown address and 2'b10 for forwarded. While `rsp_valid` is low the code is 2'b00 and `rsp_rdata` is zero. `rsp_rdata` is also zero for writes and for any reply other than an ok read.
- R3: A read of address 0x0000 returns `{temp_i[11:0], 7'b0, flags_i[12:0]}`, sampled in the command cycle. A write to it returns unknown address.
- R4: A write to 0x0020 drives the written word on `pulse_o` for exactly the reply cycle, and `pulse_o` is zero in every other cycle. A read of 0x0020 returns unknown address.
- R5: Addresses 0x0021 and 0x0022 are read/write words that reset to `CTL_A_INIT` and `CTL_B_INIT`. Word 0x0021 is on `ctl_a_o`. Word 0x0022 drives `fe_enable_o` from bits 15..0, `fmt_sel_o` from bits 23..20, `dbg_en_o` from bit 30 and `trig_en_o` from bit 31. A written value shows on the outputs from the reply cycle onward.
- R6: Reads of 0x0040, 0x0041 and 0x0042 return `COMPILE_TIME`, `DESIGN_VER` and `HW_INFO`. The upper half of `HW_INFO` is the hardware type. Writes to these addresses return unknown address.
- R7: A read of 0x0080+i, for i below 2**`STAT_LOG2`, returns word i of `usr_stat_i` and raises bit i of `usr_stat_stb_o` for the reply cycle only. A write there, or any access beyond the bank, returns unknown address.
- R8: Address 0x00C0+i, for i below 2**`CTRL_LOG2`, is read/write and resets to `USR_CTRL_INIT`. It is visible as word i of `usr_ctrl_o`. A write raises bit i of `usr_ctrl_stb_o` for the reply cycle, and a read raises no control strobe.
- R9: A rejected access changes no control word, user control register, strobe or pulse output.
- R10: With `EXT_EN`=1, any access at 0x0100 or above replies forwarded and raises `ext_req_o` for the reply cycle. It also presents the address, direction and write data on `ext_addr_o`, `ext_write_o` and `ext_wdata_o`. With `EXT_EN`=0 the same access replies unknown address and `ext_req_o` stays low.
- R11: Every local address below 0x0100 that is not listed in R3 to R8 returns unknown address for both reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 16 | Word address |
| cmd_wdata | input | 32 | Write data |
| temp_i | input | 12 | Temperature field of the status word |
| flags_i | input | 13 | Error and warning flags of the status word |
| usr_stat_i | input | 32*2**STAT_LOG2 | User status words, word i in bits 32i+31..32i |
| rsp_valid | output | 1 | Reply present |
| rsp_code | output | 2 | Reply code |
| rsp_rdata | output | 32 | Read data |
| pulse_o | output | 32 | One-cycle command pulses |
| ctl_a_o | output | 32 | Control word 0x0021 |
| fe_enable_o | output | 16 | Frontend enables |
| fmt_sel_o | output | 4 | Data format select |
| dbg_en_o | output | 1 | Debug enable |
| trig_en_o | output | 1 | Trigger enable |
| usr_ctrl_o | output | 32*2**CTRL_LOG2 | User control words |
| usr_stat_stb_o | output | 2**STAT_LOG2 | Per-register read strobes |
| usr_ctrl_stb_o | output | 2**CTRL_LOG2 | Per-register write strobes |
| ext_req_o | output | 1 | Forwarded access on the external port |
| ext_write_o | output | 1 | Direction of the forwarded access |
| ext_addr_o | output | 16 | Address of the forwarded access |
| ext_wdata_o | output | 32 | Write data of the forwarded access |

## Verification
Some properties can be checked on every cycle: the one-cycle reply timing, the idle state of the code when no reply is present, and the one-hot, read-only or write-only nature of each strobe. Others are also checked each cycle: pulses appear only with an ok reply, the external request matches the forwarded code, and control words stay unchanged whenever a reply reports an error. Only the bench scenarios can show that each address gives the right data, code and register effect. That covers the status word layout, the parameter words, bank bounds, unmapped holes and the difference between the port-enabled and port-disabled builds.

// File: rtl/sc_ep_pkg.sv
package sc_ep_pkg;

  typedef enum logic [1:0] {
    RSP_OK      = 2'b00,
    RSP_UNKNOWN = 2'b01,
    RSP_FWD     = 2'b10
  } rsp_code_e;

  typedef enum logic [3:0] {
    RG_NONE,
    RG_STATUS,
    RG_PULSE,
    RG_CTLA,
    RG_CTLB,
    RG_ROM_TIME,
    RG_ROM_VER,
    RG_ROM_HW,
    RG_USTAT,
    RG_UCTRL,
    RG_EXT
  } region_e;

  localparam logic [7:0]  OFS_STATUS = 8'h00;
  localparam logic [7:0]  OFS_PULSE  = 8'h20;
  localparam logic [7:0]  OFS_CTLA   = 8'h21;
  localparam logic [7:0]  OFS_CTLB   = 8'h22;
  localparam logic [7:0]  OFS_TIME   = 8'h40;
  localparam logic [7:0]  OFS_VER    = 8'h41;
  localparam logic [7:0]  OFS_HW     = 8'h42;
  localparam logic [1:0]  BANK_USTAT = 2'b10;
  localparam logic [1:0]  BANK_UCTRL = 2'b11;
  localparam logic [15:0] EXT_BASE   = 16'h0100;

endpackage

// File: rtl/sc_ep_decode.sv
module sc_ep_decode
  import sc_ep_pkg::*;
#(
  parameter int STAT_N = 4,
  parameter int CTRL_N = 4,
  parameter bit EXT_EN = 1'b1
) (
  input  logic [15:0] addr,
  input  logic        write,
  output region_e     region,
  output logic [5:0]  idx,
  output rsp_code_e   code
);

  always_comb begin
    region = RG_NONE;
    idx    = addr[5:0];
    if (addr >= EXT_BASE) begin
      region = RG_EXT;
    end else if (addr[7:6] == BANK_UCTRL) begin
      if (int'(addr[5:0]) < CTRL_N) region = RG_UCTRL;
    end else if (addr[7:6] == BANK_USTAT) begin
      if (int'(addr[5:0]) < STAT_N) region = RG_USTAT;
    end else begin
      case (addr[7:0])
        OFS_STATUS: region = RG_STATUS;
        OFS_PULSE:  region = RG_PULSE;
        OFS_CTLA:   region = RG_CTLA;
        OFS_CTLB:   region = RG_CTLB;
        OFS_TIME:   region = RG_ROM_TIME;
        OFS_VER:    region = RG_ROM_VER;
        OFS_HW:     region = RG_ROM_HW;
        default:    region = RG_NONE;
      endcase
    end
  end

  always_comb begin
    unique case (region)
      RG_STATUS, RG_ROM_TIME, RG_ROM_VER, RG_ROM_HW, RG_USTAT:
        code = write ? RSP_UNKNOWN : RSP_OK;
      RG_PULSE:
        code = write ? RSP_OK : RSP_UNKNOWN;
      RG_CTLA, RG_CTLB, RG_UCTRL:
        code = RSP_OK;
      RG_EXT:
        code = EXT_EN ? RSP_FWD : RSP_UNKNOWN;
      default:
        code = RSP_UNKNOWN;
    endcase
  end

endmodule

// File: rtl/sc_ep_ctrl_bank.sv
module sc_ep_ctrl_bank #(
  parameter int          N    = 4,
  parameter logic [31:0] INIT = 32'h0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [5:0]    wr_idx,
  input  logic [31:0]   wdata,
  output logic [N*32-1:0] regs
);

  for (genvar g = 0; g < N; g++) begin : g_word
    logic        ce;
    logic [31:0] word_q;

    assign ce = wr_en && (int'(wr_idx) == g);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= INIT;
      end else if (ce) begin
        word_q <= wdata;
      end
    end

    assign regs[g*32 +: 32] = word_q;
  end

endmodule

// File: rtl/sc_ep_reply.sv
module sc_ep_reply
  import sc_ep_pkg::*;
#(
  parameter int          STAT_N       = 4,
  parameter int          CTRL_N       = 4,
  parameter logic [31:0] COMPILE_TIME = 32'h0,
  parameter logic [31:0] DESIGN_VER   = 32'h0,
  parameter logic [31:0] HW_INFO      = 32'h0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic                 cmd_write,
  input  region_e              region,
  input  logic [5:0]           idx,
  input  rsp_code_e            code,
  input  logic [31:0]          status_word,
  input  logic [31:0]          ctl_a,
  input  logic [31:0]          ctl_b,
  input  logic [STAT_N*32-1:0] usr_stat,
  input  logic [CTRL_N*32-1:0] usr_ctrl,
  output logic                 rsp_valid,
  output logic [1:0]           rsp_code,
  output logic [31:0]          rsp_rdata
);

  logic [31:0] rd_word;
  logic        valid_d;
  logic [1:0]  code_d;
  logic [31:0] rdata_d;

  always_comb begin
    rd_word = '0;
    unique case (region)
      RG_STATUS:   rd_word = status_word;
      RG_CTLA:     rd_word = ctl_a;
      RG_CTLB:     rd_word = ctl_b;
      RG_ROM_TIME: rd_word = COMPILE_TIME;
      RG_ROM_VER:  rd_word = DESIGN_VER;
      RG_ROM_HW:   rd_word = HW_INFO;
      RG_USTAT: begin
        for (int i = 0; i < STAT_N; i++)
          if (int'(idx) == i) rd_word = usr_stat[i*32 +: 32];
      end
      RG_UCTRL: begin
        for (int i = 0; i < CTRL_N; i++)
          if (int'(idx) == i) rd_word = usr_ctrl[i*32 +: 32];
      end
      default:     rd_word = '0;
    endcase
  end

  always_comb begin
    valid_d = cmd_valid;
    code_d  = cmd_valid ? code : RSP_OK;
    rdata_d = (cmd_valid && !cmd_write && code == RSP_OK) ? rd_word : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_code  <= RSP_OK;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= valid_d;
      rsp_code  <= code_d;
      rsp_rdata <= rdata_d;
    end
  end

endmodule

// File: rtl/sc_reg_endpoint.sv
module sc_reg_endpoint
  import sc_ep_pkg::*;
#(
  parameter int          STAT_LOG2     = 2,
  parameter int          CTRL_LOG2     = 2,
  parameter bit          EXT_EN        = 1'b1,
  parameter logic [31:0] CTL_A_INIT    = 32'h0000_0001,
  parameter logic [31:0] CTL_B_INIT    = 32'h8000_00FF,
  parameter logic [31:0] USR_CTRL_INIT = 32'hC0DE_0000,
  parameter logic [31:0] COMPILE_TIME  = 32'h4C10_E2F7,
  parameter logic [31:0] DESIGN_VER    = 32'h0002_0011,
  parameter logic [31:0] HW_INFO       = 32'h3300_0001,
  localparam int         STAT_N        = 1 << STAT_LOG2,
  localparam int         CTRL_N        = 1 << CTRL_LOG2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic                 cmd_write,
  input  logic [15:0]          cmd_addr,
  input  logic [31:0]          cmd_wdata,
  input  logic [11:0]          temp_i,
  input  logic [12:0]          flags_i,
  input  logic [STAT_N*32-1:0] usr_stat_i,
  output logic                 rsp_valid,
  output logic [1:0]           rsp_code,
  output logic [31:0]          rsp_rdata,
  output logic [31:0]          pulse_o,
  output logic [31:0]          ctl_a_o,
  output logic [15:0]          fe_enable_o,
  output logic [3:0]           fmt_sel_o,
  output logic                 dbg_en_o,
  output logic                 trig_en_o,
  output logic [CTRL_N*32-1:0] usr_ctrl_o,
  output logic [STAT_N-1:0]    usr_stat_stb_o,
  output logic [CTRL_N-1:0]    usr_ctrl_stb_o,
  output logic                 ext_req_o,
  output logic                 ext_write_o,
  output logic [15:0]          ext_addr_o,
  output logic [31:0]          ext_wdata_o
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  // address decode
  region_e   dec_region;
  logic [5:0] dec_idx;
  rsp_code_e dec_code;

  sc_ep_decode #(.STAT_N(STAT_N), .CTRL_N(CTRL_N), .EXT_EN(EXT_EN)) u_decode (
    .addr   (cmd_addr),
    .write  (cmd_write),
    .region (dec_region),
    .idx    (dec_idx),
    .code   (dec_code)
  );

  logic acc_ok, wr_ok, rd_ok, fwd;
  assign acc_ok = cmd_valid && (dec_code == RSP_OK);
  assign wr_ok  = acc_ok && cmd_write;
  assign rd_ok  = acc_ok && !cmd_write;
  assign fwd    = cmd_valid && (dec_code == RSP_FWD);

  // control storage
  logic [31:0] ctl_a_q, ctl_b_q;

  sc_ep_ctrl_bank #(.N(1), .INIT(CTL_A_INIT)) u_ctla (
    .clk(clk), .rst_n(rst_s), .wr_en(wr_ok && dec_region == RG_CTLA),
    .wr_idx(6'd0), .wdata(cmd_wdata), .regs(ctl_a_q)
  );

  sc_ep_ctrl_bank #(.N(1), .INIT(CTL_B_INIT)) u_ctlb (
    .clk(clk), .rst_n(rst_s), .wr_en(wr_ok && dec_region == RG_CTLB),
    .wr_idx(6'd0), .wdata(cmd_wdata), .regs(ctl_b_q)
  );

  sc_ep_ctrl_bank #(.N(CTRL_N), .INIT(USR_CTRL_INIT)) u_uctrl (
    .clk(clk), .rst_n(rst_s), .wr_en(wr_ok && dec_region == RG_UCTRL),
    .wr_idx(dec_idx), .wdata(cmd_wdata), .regs(usr_ctrl_o)
  );

  // reply path
  logic [31:0] status_word;
  assign status_word = {temp_i, 7'b0, flags_i};

  sc_ep_reply #(
    .STAT_N(STAT_N), .CTRL_N(CTRL_N), .COMPILE_TIME(COMPILE_TIME),
    .DESIGN_VER(DESIGN_VER), .HW_INFO(HW_INFO)
  ) u_reply (
    .clk(clk), .rst_n(rst_s), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .region(dec_region), .idx(dec_idx), .code(dec_code),
    .status_word(status_word), .ctl_a(ctl_a_q), .ctl_b(ctl_b_q),
    .usr_stat(usr_stat_i), .usr_ctrl(usr_ctrl_o),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_rdata(rsp_rdata)
  );

  // strobes, pulses and external request: next state
  logic [31:0]       pulse_d;
  logic [STAT_N-1:0] sstb_d;
  logic [CTRL_N-1:0] cstb_d;
  logic              ext_ce;

  always_comb begin
    pulse_d = (wr_ok && dec_region == RG_PULSE) ? cmd_wdata : '0;
    for (int i = 0; i < STAT_N; i++)
      sstb_d[i] = rd_ok && (dec_region == RG_USTAT) && (int'(dec_idx) == i);
    for (int i = 0; i < CTRL_N; i++)
      cstb_d[i] = wr_ok && (dec_region == RG_UCTRL) && (int'(dec_idx) == i);
    ext_ce = fwd;
  end

  // strobes, pulses and external request: registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      pulse_o        <= '0;
      usr_stat_stb_o <= '0;
      usr_ctrl_stb_o <= '0;
      ext_req_o      <= 1'b0;
    end else begin
      pulse_o        <= pulse_d;
      usr_stat_stb_o <= sstb_d;
      usr_ctrl_stb_o <= cstb_d;
      ext_req_o      <= fwd;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ext_write_o <= 1'b0;
      ext_addr_o  <= '0;
      ext_wdata_o <= '0;
    end else if (ext_ce) begin
      ext_write_o <= cmd_write;
      ext_addr_o  <= cmd_addr;
      ext_wdata_o <= cmd_wdata;
    end
  end

  assign ctl_a_o     = ctl_a_q;
  assign fe_enable_o = ctl_b_q[15:0];
  assign fmt_sel_o   = ctl_b_q[23:20];
  assign dbg_en_o    = ctl_b_q[30];
  assign trig_en_o   = ctl_b_q[31];

endmodule

// File: rtl/sc_ep_checker.sv
module sc_ep_checker #(
  parameter int STAT_LOG2 = 2,
  parameter int CTRL_LOG2 = 2,
  localparam int STAT_N = 1 << STAT_LOG2,
  localparam int CTRL_N = 1 << CTRL_LOG2
) (
  input logic                 clk,
  input logic                 rst_s,
  input logic                 cmd_valid,
  input logic                 cmd_write,
  input logic                 rsp_valid,
  input logic [1:0]           rsp_code,
  input logic [31:0]          rsp_rdata,
  input logic [31:0]          pulse_o,
  input logic [31:0]          ctl_a_o,
  input logic [31:0]          ctl_b_q,
  input logic [CTRL_N*32-1:0] usr_ctrl_o,
  input logic [STAT_N-1:0]    usr_stat_stb_o,
  input logic [CTRL_N-1:0]    usr_ctrl_stb_o,
  input logic                 ext_req_o
);

  assert_reply_follows_R1: assert property (@(posedge clk) disable iff (!rst_s)
    cmd_valid |=> rsp_valid);

  assert_no_spurious_reply_R1: assert property (@(posedge clk) disable iff (!rst_s)
    !cmd_valid |=> !rsp_valid);

  assert_idle_reply_clear_R2: assert property (@(posedge clk) disable iff (!rst_s)
    !rsp_valid |-> (rsp_code == 2'b00 && rsp_rdata == 32'h0));

  assert_code_legal_R2: assert property (@(posedge clk) disable iff (!rst_s)
    rsp_valid |-> rsp_code != 2'b11);

  assert_pulse_with_ok_R4: assert property (@(posedge clk) disable iff (!rst_s)
    (pulse_o != 32'h0) |-> (rsp_valid && rsp_code == 2'b00));

  assert_pulse_needs_write_R4: assert property (@(posedge clk) disable iff (!rst_s)
    (cmd_valid && !cmd_write) |=> pulse_o == 32'h0);

  assert_stat_stb_onehot_R7: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0(usr_stat_stb_o));

  assert_stat_stb_on_read_R7: assert property (@(posedge clk) disable iff (!rst_s)
    (cmd_valid && cmd_write) |=> usr_stat_stb_o == '0);

  assert_ctrl_stb_onehot_R8: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0(usr_ctrl_stb_o));

  assert_ctrl_stb_on_write_R8: assert property (@(posedge clk) disable iff (!rst_s)
    (cmd_valid && !cmd_write) |=> usr_ctrl_stb_o == '0);

  assert_uctrl_change_has_stb_R8: assert property (@(posedge clk) disable iff (!rst_s)
    !$stable(usr_ctrl_o) |-> (usr_ctrl_stb_o != '0));

  assert_error_holds_state_R9: assert property (@(posedge clk) disable iff (!rst_s)
    (rsp_valid && rsp_code != 2'b00) |->
      ($stable(ctl_a_o) && $stable(ctl_b_q) && $stable(usr_ctrl_o) &&
       usr_stat_stb_o == '0 && usr_ctrl_stb_o == '0 && pulse_o == 32'h0));

  assert_ext_req_fwd_R10: assert property (@(posedge clk) disable iff (!rst_s)
    ext_req_o |-> (rsp_valid && rsp_code == 2'b10));

  assert_fwd_has_req_R10: assert property (@(posedge clk) disable iff (!rst_s)
    (rsp_valid && rsp_code == 2'b10) |-> ext_req_o);

endmodule

bind sc_reg_endpoint sc_ep_checker #(.STAT_LOG2(STAT_LOG2), .CTRL_LOG2(CTRL_LOG2)) u_chk (
  .clk            (clk),
  .rst_s          (rst_s),
  .cmd_valid      (cmd_valid),
  .cmd_write      (cmd_write),
  .rsp_valid      (rsp_valid),
  .rsp_code       (rsp_code),
  .rsp_rdata      (rsp_rdata),
  .pulse_o        (pulse_o),
  .ctl_a_o        (ctl_a_o),
  .ctl_b_q        (ctl_b_q),
  .usr_ctrl_o     (usr_ctrl_o),
  .usr_stat_stb_o (usr_stat_stb_o),
  .usr_ctrl_stb_o (usr_ctrl_stb_o),
  .ext_req_o      (ext_req_o)
);

// File: tb/sc_reg_endpoint_bench.sv
module sc_reg_endpoint_bench;

  localparam int SN = 4;
  localparam int CN = 4;
  localparam logic [31:0] P_CTLA = 32'h0000_0001;
  localparam logic [31:0] P_CTLB = 32'h8000_00FF;
  localparam logic [31:0] P_UCTL = 32'hC0DE_0000;
  localparam logic [31:0] P_TIME = 32'h4C10_E2F7;
  localparam logic [31:0] P_VER  = 32'h0002_0011;
  localparam logic [31:0] P_HW   = 32'h3300_0001;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n;
  logic              cmd_valid, cmd_write;
  logic [15:0]       cmd_addr;
  logic [31:0]       cmd_wdata;
  logic [11:0]       temp_i;
  logic [12:0]       flags_i;
  logic [SN*32-1:0]  usr_stat_i;

  logic              rsp_valid;
  logic [1:0]        rsp_code;
  logic [31:0]       rsp_rdata, pulse_o, ctl_a_o;
  logic [15:0]       fe_enable_o;
  logic [3:0]        fmt_sel_o;
  logic              dbg_en_o, trig_en_o;
  logic [CN*32-1:0]  usr_ctrl_o;
  logic [SN-1:0]     usr_stat_stb_o;
  logic [CN-1:0]     usr_ctrl_stb_o;
  logic              ext_req_o, ext_write_o;
  logic [15:0]       ext_addr_o;
  logic [31:0]       ext_wdata_o;

  logic              nx_valid;
  logic [1:0]        nx_code;
  logic [31:0]       nx_rdata, nx_pulse, nx_ctla;
  logic [15:0]       nx_fe;
  logic [3:0]        nx_fmt;
  logic              nx_dbg, nx_trig;
  logic [CN*32-1:0]  nx_uctrl;
  logic [SN-1:0]     nx_sstb;
  logic [CN-1:0]     nx_cstb;
  logic              nx_ext_req, nx_ext_we;
  logic [15:0]       nx_ext_addr;
  logic [31:0]       nx_ext_wdata;

  sc_reg_endpoint u_sc_reg_endpoint (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .temp_i(temp_i), .flags_i(flags_i),
    .usr_stat_i(usr_stat_i), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
    .rsp_rdata(rsp_rdata), .pulse_o(pulse_o), .ctl_a_o(ctl_a_o),
    .fe_enable_o(fe_enable_o), .fmt_sel_o(fmt_sel_o), .dbg_en_o(dbg_en_o),
    .trig_en_o(trig_en_o), .usr_ctrl_o(usr_ctrl_o), .usr_stat_stb_o(usr_stat_stb_o),
    .usr_ctrl_stb_o(usr_ctrl_stb_o), .ext_req_o(ext_req_o), .ext_write_o(ext_write_o),
    .ext_addr_o(ext_addr_o), .ext_wdata_o(ext_wdata_o)
  );

  sc_reg_endpoint #(.EXT_EN(1'b0)) u_noext (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .temp_i(temp_i), .flags_i(flags_i),
    .usr_stat_i(usr_stat_i), .rsp_valid(nx_valid), .rsp_code(nx_code),
    .rsp_rdata(nx_rdata), .pulse_o(nx_pulse), .ctl_a_o(nx_ctla),
    .fe_enable_o(nx_fe), .fmt_sel_o(nx_fmt), .dbg_en_o(nx_dbg),
    .trig_en_o(nx_trig), .usr_ctrl_o(nx_uctrl), .usr_stat_stb_o(nx_sstb),
    .usr_ctrl_stb_o(nx_cstb), .ext_req_o(nx_ext_req), .ext_write_o(nx_ext_we),
    .ext_addr_o(nx_ext_addr), .ext_wdata_o(nx_ext_wdata)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // reference model state
  logic [31:0] m_ctla, m_ctlb;
  logic [31:0] m_uc [CN];
  // expected outputs after the next edge
  logic        e_valid, e_ext, e_ext_we;
  logic [1:0]  e_code, e_code_nx;
  logic [31:0] e_rdata, e_pulse, e_ext_wdata;
  logic [15:0] e_ext_addr;
  logic [SN-1:0] e_sstb;
  logic [CN-1:0] e_cstb;

  task automatic check(input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // code per the requirements: 0 ok, 1 unknown, 2 forwarded
  function automatic logic [1:0] exp_code(logic [15:0] a, bit w, bit ext);
    if (a >= 16'h0100) return ext ? 2'd2 : 2'd1;
    if (a >= 16'h00C0 && a < 16'h00C0 + CN) return 2'd0;
    if (a >= 16'h0080 && a < 16'h0080 + SN) return w ? 2'd1 : 2'd0;
    case (a)
      16'h0000, 16'h0040, 16'h0041, 16'h0042: return w ? 2'd1 : 2'd0;
      16'h0020: return w ? 2'd0 : 2'd1;
      16'h0021, 16'h0022: return 2'd0;
      default: return 2'd1;
    endcase
  endfunction

  function automatic logic [31:0] exp_read(logic [15:0] a);
    if (a >= 16'h00C0 && a < 16'h00C0 + CN) return m_uc[a - 16'h00C0];
    if (a >= 16'h0080 && a < 16'h0080 + SN) return usr_stat_i[(a - 16'h0080)*32 +: 32];
    case (a)
      16'h0000: return {temp_i, 7'b0, flags_i};
      16'h0021: return m_ctla;
      16'h0022: return m_ctlb;
      16'h0040: return P_TIME;
      16'h0041: return P_VER;
      16'h0042: return P_HW;
      default:  return 32'h0;
    endcase
  endfunction

  function automatic logic [CN*32-1:0] m_uc_flat();
    logic [CN*32-1:0] f;
    for (int i = 0; i < CN; i++) f[i*32 +: 32] = m_uc[i];
    return f;
  endfunction

  task automatic compare_all(input string tag);
    check(tag, "rsp_valid", rsp_valid, e_valid);
    check(tag, "rsp_code", rsp_code, e_code);
    check(tag, "rsp_rdata", rsp_rdata, e_rdata);
    check(tag, "pulse_o", pulse_o, e_pulse);
    check(tag, "ctl_a_o", ctl_a_o, m_ctla);
    check(tag, "fe_enable_o", fe_enable_o, m_ctlb[15:0]);
    check(tag, "fmt_sel_o", fmt_sel_o, m_ctlb[23:20]);
    check(tag, "dbg_en_o", dbg_en_o, m_ctlb[30]);
    check(tag, "trig_en_o", trig_en_o, m_ctlb[31]);
    check(tag, "usr_ctrl_o", usr_ctrl_o, m_uc_flat());
    check(tag, "usr_stat_stb_o", usr_stat_stb_o, e_sstb);
    check(tag, "usr_ctrl_stb_o", usr_ctrl_stb_o, e_cstb);
    check(tag, "ext_req_o", ext_req_o, e_ext);
    if (e_ext) begin
      check(tag, "ext_addr_o", ext_addr_o, e_ext_addr);
      check(tag, "ext_write_o", ext_write_o, e_ext_we);
      check(tag, "ext_wdata_o", ext_wdata_o, e_ext_wdata);
    end
    check(tag, "noext rsp_code", nx_code, e_code_nx);
    check(tag, "noext ext_req_o", nx_ext_req, 1'b0);
  endtask

  // one clock: drive at the falling edge, compare at the next falling edge
  task automatic step(input string tag, input bit v, input bit w,
                      input logic [15:0] a, input logic [31:0] d);
    cmd_valid = v; cmd_write = w; cmd_addr = a; cmd_wdata = d;
    e_valid = v; e_code = 2'd0; e_code_nx = 2'd0; e_rdata = '0; e_pulse = '0;
    e_sstb = '0; e_cstb = '0; e_ext = 1'b0;
    if (v) begin
      e_code    = exp_code(a, w, 1'b1);
      e_code_nx = exp_code(a, w, 1'b0);
      if (e_code == 2'd0 && !w) begin
        e_rdata = exp_read(a);
        if (a >= 16'h0080 && a < 16'h0080 + SN) e_sstb[a - 16'h0080] = 1'b1;
      end
      if (e_code == 2'd0 && w) begin
        if (a == 16'h0020) e_pulse = d;
        if (a == 16'h0021) m_ctla = d;
        if (a == 16'h0022) m_ctlb = d;
        if (a >= 16'h00C0 && a < 16'h00C0 + CN) begin
          m_uc[a - 16'h00C0] = d;
          e_cstb[a - 16'h00C0] = 1'b1;
        end
      end
      if (e_code == 2'd2) begin
        e_ext = 1'b1; e_ext_addr = a; e_ext_we = w; e_ext_wdata = d;
      end
    end
    @(posedge clk);
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic rd(input string tag, input logic [15:0] a);
    step(tag, 1'b1, 1'b0, a, 32'hDEAD_BEEF);
  endtask

  task automatic wr(input string tag, input logic [15:0] a, input logic [31:0] d);
    step(tag, 1'b1, 1'b1, a, d);
  endtask

  task automatic idle(input string tag);
    step(tag, 1'b0, 1'b0, 16'h0, 32'h0);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cyc);
        finish_run();
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    cmd_valid = 1'b0; cmd_write = 1'b0; cmd_addr = '0; cmd_wdata = '0;
    temp_i = 12'hABC; flags_i = 13'h1555;
    for (int i = 0; i < SN; i++) usr_stat_i[i*32 +: 32] = 32'h1111_0000 * (i + 1) + 32'hA5 + i;
    m_ctla = P_CTLA; m_ctlb = P_CTLB;
    for (int i = 0; i < CN; i++) m_uc[i] = P_UCTL;
    e_valid = 0; e_code = 0; e_code_nx = 0; e_rdata = 0; e_pulse = 0;
    e_sstb = 0; e_cstb = 0; e_ext = 0; e_ext_we = 0; e_ext_addr = 0; e_ext_wdata = 0;

    repeat (3) @(negedge clk);
    // reset state: control words at their init values (R5, R8), no reply (R1)
    compare_all("R5");
    compare_all("R8");
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) idle("R1");

    // R3: status word layout, live sampling, write rejected
    rd("R3", 16'h0000);
    flags_i = 13'h0AAA; temp_i = 12'h123;
    rd("R3", 16'h0000);
    wr("R3", 16'h0000, 32'h1234_5678);

    // R4: pulse word
    wr("R4", 16'h0020, 32'h00C9_800B);
    idle("R4");
    rd("R4", 16'h0020);
    wr("R4", 16'h0020, 32'h0000_0001);
    wr("R4", 16'h0020, 32'h8000_0000);

    // R5: control words and decoded fields
    wr("R5", 16'h0021, 32'hCAFE_F00D);
    rd("R5", 16'h0021);
    wr("R5", 16'h0022, 32'hC0A5_1234);
    rd("R5", 16'h0022);
    wr("R5", 16'h0022, 32'h3F50_0000);
    rd("R5", 16'h0022);

    // R6: parameter words, write rejected
    rd("R6", 16'h0040);
    rd("R6", 16'h0041);
    rd("R6", 16'h0042);
    wr("R6", 16'h0041, 32'hFFFF_FFFF);
    rd("R6", 16'h0041);

    // R7: user status bank with per-register read strobes
    for (int i = 0; i < SN; i++) rd("R7", 16'h0080 + 16'(i));
    rd("R7", 16'h0080 + 16'(SN));
    wr("R7", 16'h0081, 32'h5555_5555);
    idle("R7");

    // R8: user control bank with per-register write strobes
    for (int i = 0; i < CN; i++) wr("R8", 16'h00C0 + 16'(i), 32'h0BAD_0000 + 32'(i));
    for (int i = 0; i < CN; i++) rd("R8", 16'h00C0 + 16'(i));
    rd("R8", 16'h00C0 + 16'(CN));
    wr("R8", 16'h00C5, 32'h7777_7777);

    // R9: rejected writes leave everything unchanged
    wr("R9", 16'h0000, 32'hFFFF_FFFF);
    wr("R9", 16'h0040, 32'hFFFF_FFFF);
    wr("R9", 16'h0010, 32'hFFFF_FFFF);
    wr("R9", 16'h00BF, 32'hFFFF_FFFF);
    rd("R9", 16'h0021);
    rd("R9", 16'h0022);
    rd("R9", 16'h00C2);

    // R10: external region, enabled and disabled builds
    wr("R10", 16'h0100, 32'h1357_9BDF);
    rd("R10", 16'hA000);
    idle("R10");
    rd("R10", 16'hFFFF);
    wr("R10", 16'h7001, 32'h0246_8ACE);

    // R11: unmapped local holes
    rd("R11", 16'h0001);
    rd("R11", 16'h0023);
    wr("R11", 16'h0043, 32'h1);
    rd("R11", 16'h0050);
    rd("R11", 16'h007F);
    wr("R11", 16'h00FF, 32'h2);

    // R1, R2: back-to-back mix followed by gaps
    wr("R2", 16'h00C1, 32'h0F0F_0F0F);
    rd("R2", 16'h0200);
    rd("R2", 16'h0033);
    rd("R2", 16'h00C1);
    idle("R1");
    idle("R1");

    finish_run();
  end

endmodule